// File: doc/BRIEF.md
# Dual Edge-Selectable Decade/Binary Counter

This block holds two independent up-counters, channel A and channel B. Each channel has a count-pulse line, an enable line, an active-high clear and a count output. A parameter sets both channels to decade counting (0 through 9) or to plain binary counting (0 through 2^WIDTH-1).

The pulse and enable lines are asynchronous levels. They are synchronized to a fast free-running system clock, and their edges are detected inside the block. A channel advances on a rising pulse edge while enable is high. It also advances on a falling enable edge while the pulse line is low. Because of the second condition, stages can be chained: the top count bit of one channel drives the enable line of the next channel, whose pulse line is held low. The next channel then steps each time the previous channel wraps to zero.

The clear input works on the system clock, is not synchronized, and overrides counting. A global active-low reset initializes the synchronizers, the previous-sample registers and the counts.

Top module: `dual_tally_counter`

## Requirements
- R1: While rst_n is low and on the first cycles after its release, both count outputs read 0.
- R2: With the enable line high, a rising edge on a channel's pulse line increments that channel's count by one. The new value appears after the third rising system-clock edge that follows the input change.
- R3: With the pulse line low, a falling edge on a channel's enable line increments that channel's count by one, with the same three-edge latency as R2.
- R4: A channel does not count in these cases: a pulse edge while enable is low, an enable edge while the pulse line is high, a rising enable edge, a falling pulse edge, a pulse rise and an enable fall in the same cycle, or inputs that stay constant. A change of count is never larger than one step.
- R5: With MODE set to decade, the count runs 0..9 and steps from 9 to 0. It never holds a value above 9.
- R6: With MODE set to binary, the count runs 0..2^WIDTH-1 and steps from the maximum to 0. With WIDTH=4 this is 15 to 0.
- R7: A channel's clear, when high at a system-clock edge, sets that channel's count to 0 at that edge. This holds even if a count event occurs in the same cycle.
- R8: Edges that reach the count logic while clear is high are dropped. After clear falls, the count resumes from 0 on the next qualifying edge.
- R9: The clear, inputs and count of one channel have no effect on the other channel.
- R10: When channel A's top count bit drives channel B's enable line and channel B's pulse line is held low, channel B steps once each time channel A wraps to 0. In decade mode that is 9 to 0; in binary mode it is 2^WIDTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| pulse_a | input | 1 | Channel A count-pulse line (asynchronous) |
| gate_a | input | 1 | Channel A enable line (asynchronous) |
| clr_a | input | 1 | Channel A clear, active high, synchronous |
| cnt_a | output | WIDTH | Channel A count; the MSB is the cascade output |
| pulse_b | input | 1 | Channel B count-pulse line (asynchronous) |
| gate_b | input | 1 | Channel B enable line (asynchronous) |
| clr_b | input | 1 | Channel B clear, active high, synchronous |
| cnt_b | output | WIDTH | Channel B count; the MSB is the cascade output |

## Verification
The assertions check, on every cycle, that a count moves only after a detected event or a clear and by no more than one step. They also check that a clear always leaves zero, that the wrap point returns to zero, and that a decade count never leaves 0..9. Only the bench scenarios can show which input patterns count as events: the non-qualifying edge combinations, edges dropped during a clear, the three-edge latency, independence of the channels, and the ripple carry when channel A's top bit drives channel B's enable.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_DECADE = 1'b1
    } tally_mode_e;

    // Two-flop synchronizer plus previous-sample register for both input lines
    typedef struct packed {
        logic [1:0] pulse_pipe;
        logic [1:0] gate_pipe;
        logic       pulse_prev;
        logic       gate_prev;
    } edge_state_t;

    function automatic int unsigned tally_last(input tally_mode_e mode, input int unsigned width);
        if (mode == MODE_DECADE) begin
            return 9;
        end
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/tally_edge.sv
module tally_edge
    import tally_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_raw,
    input  logic gate_raw,
    output logic step
);

    edge_state_t st_d, st_q;
    logic        pulse_now, gate_now;
    logic        pulse_rise, gate_fall;

    always_comb begin
        st_d            = st_q;
        st_d.pulse_pipe = {st_q.pulse_pipe[0], pulse_raw};
        st_d.gate_pipe  = {st_q.gate_pipe[0], gate_raw};
        st_d.pulse_prev = st_q.pulse_pipe[1];
        st_d.gate_prev  = st_q.gate_pipe[1];

        pulse_now  = st_q.pulse_pipe[1];
        gate_now   = st_q.gate_pipe[1];
        pulse_rise = pulse_now & ~st_q.pulse_prev & gate_now;
        gate_fall  = ~gate_now & st_q.gate_prev & ~pulse_now;
        // Both conditions merge into a single event, so one cycle yields at most one step
        step       = pulse_rise | gate_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tally_core.sv
module tally_core
    import tally_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter tally_mode_e MODE  = MODE_DECADE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] LAST = WIDTH'(tally_last(MODE, WIDTH));
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.count = '0;
        end else if (step) begin
            if (st_q.count == LAST) begin
                st_d.count = '0;
            end else begin
                st_d.count = st_q.count + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.count;

endmodule

// File: rtl/dual_tally_counter.sv
module dual_tally_counter
    import tally_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter tally_mode_e MODE  = MODE_DECADE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_a,
    input  logic             gate_a,
    input  logic             clr_a,
    output logic [WIDTH-1:0] cnt_a,
    input  logic             pulse_b,
    input  logic             gate_b,
    input  logic             clr_b,
    output logic [WIDTH-1:0] cnt_b
);

    localparam int unsigned CHANNELS = 2;

    logic [CHANNELS-1:0]            pulse_vec;
    logic [CHANNELS-1:0]            gate_vec;
    logic [CHANNELS-1:0]            clr_vec;
    logic [CHANNELS-1:0]            step_vec;
    logic [CHANNELS-1:0][WIDTH-1:0] cnt_vec;

    assign pulse_vec = {pulse_b, pulse_a};
    assign gate_vec  = {gate_b, gate_a};
    assign clr_vec   = {clr_b, clr_a};

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        tally_edge u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse_raw (pulse_vec[ch]),
            .gate_raw  (gate_vec[ch]),
            .step      (step_vec[ch])
        );

        tally_core #(
            .WIDTH (WIDTH),
            .MODE  (MODE)
        ) u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_vec[ch]),
            .step  (step_vec[ch]),
            .value (cnt_vec[ch])
        );
    end

    assign cnt_a = cnt_vec[0];
    assign cnt_b = cnt_vec[1];

endmodule

// File: rtl/tally_chk.sv
module tally_chk
    import tally_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter tally_mode_e MODE  = MODE_DECADE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           clr_vec,
    input logic [1:0]           step_vec,
    input logic [1:0][WIDTH-1:0] cnt_vec
);

    localparam logic [WIDTH-1:0] LAST = WIDTH'(tally_last(MODE, WIDTH));
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chk
        // R4: a count moves only after an event or a clear
        p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_vec[ch] != $past(cnt_vec[ch])) |-> ($past(step_vec[ch]) || $past(clr_vec[ch])));

        // R2: an event below the wrap point advances by exactly one
        p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(step_vec[ch]) && !$past(clr_vec[ch]) && ($past(cnt_vec[ch]) != LAST))
            |-> (cnt_vec[ch] == $past(cnt_vec[ch]) + ONE));

        // R5 / R6: an event at the wrap point returns to zero
        p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(step_vec[ch]) && !$past(clr_vec[ch]) && ($past(cnt_vec[ch]) == LAST))
            |-> (cnt_vec[ch] == '0));

        // R7: clear wins over any event
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clr_vec[ch]) |-> (cnt_vec[ch] == '0));

        if (MODE == MODE_DECADE) begin : g_dec
            // R5: decade value stays within 0..9
            p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_vec[ch] <= LAST);
        end
    end

endmodule

bind dual_tally_counter tally_chk #(
    .WIDTH (WIDTH),
    .MODE  (MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_vec  (clr_vec),
    .step_vec (step_vec),
    .cnt_vec  (cnt_vec)
);

// File: tb/dual_tally_counter_tb.sv
`timescale 1ns/1ps
module dual_tally_counter_tb;
    import tally_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_a = 1'b0, gate_a = 1'b0, clr_a = 1'b0;
    logic pulse_b = 1'b0, gate_b_drv = 1'b0, clr_b = 1'b0;
    logic casc = 1'b0;

    logic [3:0] cnt_a_dec, cnt_b_dec, cnt_a_bin, cnt_b_bin;
    logic       gate_b_dec, gate_b_bin;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    assign gate_b_dec = casc ? cnt_a_dec[3] : gate_b_drv;
    assign gate_b_bin = casc ? cnt_a_bin[3] : gate_b_drv;

    dual_tally_counter #(.WIDTH(4), .MODE(MODE_DECADE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pulse_a(pulse_a), .gate_a(gate_a), .clr_a(clr_a), .cnt_a(cnt_a_dec),
        .pulse_b(pulse_b), .gate_b(gate_b_dec), .clr_b(clr_b), .cnt_b(cnt_b_dec)
    );

    dual_tally_counter #(.WIDTH(4), .MODE(MODE_BINARY)) u_dut_bin (
        .clk(clk), .rst_n(rst_n),
        .pulse_a(pulse_a), .gate_a(gate_a), .clr_a(clr_a), .cnt_a(cnt_a_bin),
        .pulse_b(pulse_b), .gate_b(gate_b_bin), .clr_b(clr_b), .cnt_b(cnt_b_bin)
    );

    // Reference model: trackers 0/1 = decade A/B, 2/3 = binary A/B
    int mcnt [4];
    bit hp [4][3];
    bit hg [4][3];
    int lim [4] = '{9, 9, 15, 15};

    function automatic int dut_val(int k);
        case (k)
            0: return int'(cnt_a_dec);
            1: return int'(cnt_b_dec);
            2: return int'(cnt_a_bin);
            default: return int'(cnt_b_bin);
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                mcnt[k] = 0;
                for (int j = 0; j < 3; j++) begin
                    hp[k][j] = 1'b0;
                    hg[k][j] = 1'b0;
                end
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                bit rp, rg, rc, s_p, s_g, o_p, o_g, ev;
                compared++;
                if (dut_val(k) != mcnt[k]) begin
                    mismatched++;
                    $display("FAIL %s tracker %0d at %0t: got %0d expected %0d",
                             cur_req, k, $time, dut_val(k), mcnt[k]);
                end
                rp = (k % 2 == 0) ? pulse_a : pulse_b;
                rc = (k % 2 == 0) ? clr_a : clr_b;
                if (k % 2 == 0) rg = gate_a;
                else if (k == 1) rg = gate_b_dec;
                else rg = gate_b_bin;
                s_p = hp[k][1]; o_p = hp[k][2];
                s_g = hg[k][1]; o_g = hg[k][2];
                ev = (s_p && !o_p && s_g) || (!s_g && o_g && !s_p);
                if (rc) mcnt[k] = 0;
                else if (ev) mcnt[k] = (mcnt[k] == lim[k]) ? 0 : mcnt[k] + 1;
                hp[k][2] = hp[k][1]; hp[k][1] = hp[k][0]; hp[k][0] = rp;
                hg[k][2] = hg[k][1]; hg[k][1] = hg[k][0]; hg[k][0] = rg;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, int got, int exp);
        @(negedge clk);
        #0.1;
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
        tick(1);
    endtask

    task automatic pulses_a(int n);
        repeat (n) begin
            pulse_a = 1'b1; tick(2);
            pulse_a = 1'b0; tick(2);
        end
    endtask

    task automatic gate_b_falls(int n);
        repeat (n) begin
            gate_b_drv = 1'b1; tick(2);
            gate_b_drv = 1'b0; tick(2);
        end
    endtask

    initial begin
        #(200000 * 5.0);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1", "cnt_a_dec in reset", int'(cnt_a_dec), 0);
        chk("R1", "cnt_b_bin in reset", int'(cnt_b_bin), 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1", "cnt_a_dec after reset", int'(cnt_a_dec), 0);

        // R2: pulse rise with enable high, three-edge latency
        cur_req = "R2";
        gate_a = 1'b1; tick(4);
        pulse_a = 1'b1;
        tick(2);
        chk("R2", "no step before third edge", int'(cnt_a_dec), 0);
        pulse_a = 1'b0; tick(3);
        chk("R2", "first step", int'(cnt_a_dec), 1);
        pulses_a(4);
        tick(3);
        chk("R2", "cnt_a_dec after five pulses", int'(cnt_a_dec), 5);
        chk("R2", "cnt_a_bin after five pulses", int'(cnt_a_bin), 5);

        // R3: enable fall with pulse low
        cur_req = "R3";
        gate_b_falls(7);
        tick(3);
        chk("R3", "cnt_b_dec after seven enable falls", int'(cnt_b_dec), 7);
        chk("R9", "cnt_a_dec untouched by channel B", int'(cnt_a_dec), 5);

        // R4: non-qualifying patterns
        cur_req = "R4";
        pulse_a = 1'b1; tick(3);
        chk("R4", "pulse rise enable high counts", int'(cnt_a_dec), 6);
        gate_a = 1'b0; tick(3);           // enable falls while pulse high
        pulse_a = 1'b0; tick(3);          // pulse falls
        pulse_a = 1'b1; tick(3);          // pulse rises with enable low
        pulse_a = 1'b0; tick(3);
        gate_a = 1'b1; tick(3);           // enable rises
        pulse_a = 1'b1; gate_a = 1'b0;    // simultaneous pulse rise and enable fall
        tick(4);
        chk("R4", "no count from non-qualifying edges", int'(cnt_a_dec), 6);
        gate_a = 1'b1; tick(3);
        pulse_a = 1'b0; tick(4);
        chk("R4", "still no count", int'(cnt_a_bin), 6);

        // R5 / R6: wrap points
        cur_req = "R5";
        pulses_a(5);
        tick(3);
        chk("R5", "decade wrap 9->0 then 1", int'(cnt_a_dec), 1);
        chk("R6", "binary at 11", int'(cnt_a_bin), 11);
        cur_req = "R6";
        pulses_a(5);
        tick(3);
        chk("R6", "binary wrap 15->0", int'(cnt_a_bin), 0);
        chk("R5", "decade at 6", int'(cnt_a_dec), 6);

        // R7 / R8: clear priority and dropped edges
        cur_req = "R7";
        clr_a = 1'b1;
        pulse_a = 1'b1; tick(1);
        chk("R7", "clear overrides event", int'(cnt_a_dec), 0);
        cur_req = "R8";
        pulse_a = 1'b0; tick(2);
        pulses_a(2);
        tick(4);
        chk("R8", "edges during clear ignored", int'(cnt_a_dec), 0);
        clr_a = 1'b0; tick(4);
        chk("R8", "no step after release alone", int'(cnt_a_bin), 0);
        pulses_a(1);
        tick(3);
        chk("R8", "resumes from zero", int'(cnt_a_dec), 1);

        // R9: independence
        cur_req = "R9";
        clr_b = 1'b1; tick(1);
        pulses_a(2);
        tick(3);
        chk("R9", "channel A counts while B clears", int'(cnt_a_dec), 3);
        chk("R9", "channel B held at zero", int'(cnt_b_dec), 0);
        clr_b = 1'b0; tick(2);

        // R10: cascade from A's top bit into B's enable
        cur_req = "R10";
        clr_a = 1'b1; clr_b = 1'b1; tick(2);
        casc = 1'b1; tick(4);
        clr_a = 1'b0; clr_b = 1'b0; tick(4);
        pulses_a(10);
        tick(4);
        chk("R10", "decade A after ten", int'(cnt_a_dec), 0);
        chk("R10", "decade B carried once", int'(cnt_b_dec), 1);
        chk("R10", "binary B no carry yet", int'(cnt_b_bin), 0);
        pulses_a(6);
        tick(4);
        chk("R10", "binary A wrapped", int'(cnt_a_bin), 0);
        chk("R10", "binary B carried once", int'(cnt_b_bin), 1);
        chk("R10", "decade B unchanged", int'(cnt_b_dec), 1);
        casc = 1'b0;
        tick(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule